// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller CPU Interface

This block sits between a bank of level-sensitive device request lines and one processor interrupt input. Every source has an enable bit, an 8-bit priority (a lower value is more urgent) and an active flag. A source counts as pending while its line is high. The controller keeps no record of edges, so it treats a request that persists and a fresh request in the same way. The processor claims the most urgent qualifying source by reading an acknowledge register. It then gives the claim back in two steps: a priority drop, which lets equal or lower sources in again, and a deactivation, which clears the active flag.

A control bit, the split bit, decides how these steps are triggered. When it is 0, an end-of-interrupt write does both the drop and the deactivation. When it is 1, the end-of-interrupt write only drops the priority, and a separate deactivate write clears the active flag. The running priority is kept as a stack of acknowledged priorities, one entry per nesting level. A new source is signalled only if it is strictly more urgent than the top entry of the stack.

The register port is plain: single-cycle read and write strobes, a 12-bit byte address, 32-bit write data and combinational read data. The port has no handshake and no back-pressure, and the caller asserts at most one strobe per cycle. All registers are 32-bit words:
- control at 0x000, with the split bit in bit 0.
- acknowledge at 0x00C (read only).
- end-of-interrupt at 0x010 and deactivate at 0x014 (write only). Both take the ID in bits 9:0.
- enable words at 0x100 + 4*w.
- active words at 0x300 + 4*w (read only).
- priorities at 0x400 + 4*id, in bits 7:0.

In each enable or active word, bit b belongs to source 32*w + b.

Top module: `irqc_level_ctrl`

## Requirements
- R1: After reset, all enables, active flags and the split bit are 0, the running-priority stack is empty, and `cpu_irq` is low even when request lines are high.
- R2: `cpu_irq` is high exactly when some source meets all of these conditions: its line is high, it is enabled, it is not active, its priority is strictly below the top of the running-priority stack (an empty stack admits every priority), and the stack is not full.
- R3: An acknowledge read returns the ID of the qualifying source with the lowest priority value, with ties going to the lower ID. The same read makes that source active and pushes its priority onto the stack.
- R4: An acknowledge read when no source qualifies returns 1023 and changes no state.
- R5: With the split bit at 0, a valid end-of-interrupt write pops the stack and clears the source's active flag.
- R6: With the split bit at 1, a valid end-of-interrupt write only pops the stack and the source stays active. A later deactivate write with its ID clears the active flag.
- R7: With the split bit at 0, a deactivate write is ignored.
- R8: An end-of-interrupt write is ignored in any of these cases: its ID is out of range, the ID was never acknowledged, or its priority was already dropped.
- R9: A source whose active flag is cleared while its line is still high is signalled again and can be acknowledged again.
- R10: A source whose enable bit is 0 is never signalled, whatever its line does.
- R11: While a claim holds the running priority, a source of equal priority is not signalled and a strictly more urgent one is.
- R12: Active flags read back as bitmaps: 0x300 covers IDs 0 to 31 and 0x304 covers IDs 32 to 63.
- R13: When the stack holds `NEST_DEPTH` entries, nothing is signalled and an acknowledge returns 1023 until a priority drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NSRC | Level request line per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on acknowledge) |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| cpu_irq | output | 1 | Processor interrupt request |

## Verification
The bench builds the block with NSRC = 40 and NEST_DEPTH = 3. Forty sources spread the active and enable bitmaps over a full first word and a partly used second word, so the padding bits of 0x304 are covered. A stack only three deep can be filled by three nested acknowledges, which brings the saturation case of R13 within a short run. A behavioural model holds the stack as a queue, and `cpu_irq` is compared against that model on every clock while the split and combined modes are both exercised.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_ACK, SEL_EOI, SEL_DEACT, SEL_EN, SEL_ACT, SEL_PRIO
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [11:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      if (a[11:10] != 2'b00) s = SEL_PRIO;
      else if (a[9:8] == 2'd1) s = SEL_EN;
      else if (a[9:8] == 2'd3) s = SEL_ACT;
      else if (a[9:8] == 2'd0) begin
        case (a[7:0])
          8'h00: s = SEL_CTRL;
          8'h0C: s = SEL_ACK;
          8'h10: s = SEL_EOI;
          8'h14: s = SEL_DEACT;
          default: s = SEL_NONE;
        endcase
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 8
) (
  input  logic [NSRC-1:0]        req,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W:0]        ceiling,
  output logic                   found,
  output logic [ID_W-1:0]        win_id,
  output logic [PRIO_W-1:0]      win_prio
);
  logic [PRIO_W:0] best_p;

  // Strict compare: the first (lowest) ID keeps a tie, and the ceiling itself never wins.
  always_comb begin
    best_p = ceiling;
    found  = 1'b0;
    win_id = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && ({1'b0, prio_flat[i*PRIO_W +: PRIO_W]} < best_p)) begin
        best_p = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]};
        found  = 1'b1;
        win_id = ID_W'(i);
      end
    end
    win_prio = best_p[PRIO_W-1:0];
  end
endmodule

// File: rtl/irqc_prio_stack.sv
module irqc_prio_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [PRIO_W:0]   ceiling,
  output logic              full,
  output logic              empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] slot [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  top_i;

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign top_i = cnt - CNT_W'(1);
  assign ceiling = empty ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, slot[top_i[PTR_W-1:0]]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push) begin
      slot[cnt[PTR_W-1:0]] <= push_prio;
      cnt <= cnt + CNT_W'(1);
    end else if (pop) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R13
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/irqc_level_ctrl.sv
module irqc_level_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC       = 64,
  parameter int PRIO_W     = 8,
  parameter int NEST_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_lines,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [11:0]     reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            cpu_irq
);
  localparam int NW = (NSRC + 31) / 32;

  logic [NSRC-1:0]        en_q, act_q, held_q;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic                   split_q;
  reg_sel_e               sel;
  logic [ID_W-1:0]        wid, pidx, win_id;
  logic [5:0]             widx;
  logic                   wid_ok, word_ok, pidx_ok;
  logic                   found, full, empty;
  logic [PRIO_W-1:0]      win_prio;
  logic [PRIO_W:0]        ceiling;
  logic                   ack_take, eoi_take, deact_take, en_wr, prio_wr;
  logic [NW*32-1:0]       en_pad, act_pad;

  assign sel     = decode_addr(reg_addr);
  assign wid     = reg_wdata[ID_W-1:0];
  assign wid_ok  = (32'(wid) < NSRC);
  assign widx    = reg_addr[7:2];
  assign word_ok = (32'(widx) < NW);
  assign pidx    = reg_addr[11:2] - 10'd256;
  assign pidx_ok = (32'(pidx) < NSRC);

  irqc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .req(irq_lines & en_q & ~act_q), .prio_flat(prio_flat), .ceiling(ceiling),
    .found(found), .win_id(win_id), .win_prio(win_prio)
  );

  irqc_prio_stack #(.DEPTH(NEST_DEPTH), .PRIO_W(PRIO_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(ack_take), .pop(eoi_take),
    .push_prio(win_prio), .ceiling(ceiling), .full(full), .empty(empty)
  );

  assign cpu_irq    = found & ~full;
  assign ack_take   = reg_rd & (sel == SEL_ACK) & cpu_irq;
  assign eoi_take   = reg_wr & (sel == SEL_EOI) & wid_ok & held_q[wid];
  assign deact_take = reg_wr & (sel == SEL_DEACT) & wid_ok & split_q;
  assign en_wr      = reg_wr & (sel == SEL_EN) & word_ok;
  assign prio_wr    = reg_wr & (sel == SEL_PRIO) & pidx_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) split_q <= 1'b0;
    else if (reg_wr && sel == SEL_CTRL) split_q <= reg_wdata[0];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic en_r, act_r, held_r;
    logic [PRIO_W-1:0] prio_r;
    logic hit_ack, hit_w;
    assign hit_ack = ack_take && (win_id == ID_W'(i));
    assign hit_w   = (wid == ID_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r   <= 1'b0;
        act_r  <= 1'b0;
        held_r <= 1'b0;
        prio_r <= '0;
      end else begin
        if (en_wr && widx == 6'(i / 32)) en_r <= reg_wdata[i % 32];
        if (prio_wr && pidx == ID_W'(i)) prio_r <= reg_wdata[PRIO_W-1:0];
        if (hit_ack) begin
          act_r  <= 1'b1;
          held_r <= 1'b1;
        end else begin
          if ((eoi_take && hit_w && !split_q) || (deact_take && hit_w)) act_r <= 1'b0;
          if (eoi_take && hit_w) held_r <= 1'b0;
        end
      end
    end
    assign en_q[i]   = en_r;
    assign act_q[i]  = act_r;
    assign held_q[i] = held_r;
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_r;
  end

  always_comb begin
    en_pad  = '0;
    act_pad = '0;
    en_pad[NSRC-1:0]  = en_q;
    act_pad[NSRC-1:0] = act_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CTRL: reg_rdata = {31'b0, split_q};
      SEL_ACK:  reg_rdata = {22'b0, (cpu_irq ? win_id : SPURIOUS_ID)};
      SEL_EN:   if (word_ok) reg_rdata = en_pad[32*widx +: 32];
      SEL_ACT:  if (word_ok) reg_rdata = act_pad[32*widx +: 32];
      SEL_PRIO: if (pidx_ok) reg_rdata = 32'(prio_flat[32'(pidx)*PRIO_W +: PRIO_W]);
      default:  reg_rdata = '0;
    endcase
  end

  // R2 R10
  irq_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> |(irq_lines & en_q & ~act_q));
  // R3
  ack_activates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> act_q[$past(win_id)]);
  // R4
  spurious_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && sel == SEL_ACK && !cpu_irq) |=> ($stable(act_q) && $stable(held_q)));
  // R7
  deact_mode0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && sel == SEL_DEACT && !split_q) |=> $stable(act_q));
  // R13
  full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !cpu_irq);
endmodule

// File: tb/sim_irqc_level_ctrl.sv
module sim_irqc_level_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NS = 40;
  localparam int DP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] lines = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          cpu_irq;

  int checks = 0, fails = 0;
  bit live = 0;

  bit m_en[NS], m_act[NS], m_held[NS];
  int m_prio[NS];
  bit m_split;
  int stk[$];

  always #2.5 clk = ~clk;

  irqc_level_ctrl #(.NSRC(NS), .PRIO_W(8), .NEST_DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  function automatic int m_best();
    int bp, best;
    if (stk.size() >= DP) return 1023;
    bp = (stk.size() == 0) ? 256 : stk[$];
    best = 1023;
    for (int i = 0; i < NS; i++)
      if (lines[i] && m_en[i] && !m_act[i] && m_prio[i] < bp) begin
        bp = m_prio[i];
        best = i;
      end
    return best;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [31:0] v;
    int w;
    v = '0;
    if (a == 12'h000) v = {31'b0, m_split};
    else if (a == 12'h00C) v = m_best();
    else if (a[11:8] == 4'h1 || a[11:8] == 4'h3) begin
      w = a[7:2];
      for (int b = 0; b < 32; b++)
        if (w * 32 + b < NS) v[b] = (a[11:8] == 4'h1) ? m_en[w*32+b] : m_act[w*32+b];
    end else if (a >= 12'h400 && (a - 12'h400) / 4 < NS) v = m_prio[(a - 12'h400) / 4];
    return v;
  endfunction

  function automatic void m_write(input logic [11:0] a, input logic [31:0] d);
    int id;
    id = d[9:0];
    if (a == 12'h000) m_split = d[0];
    else if (a == 12'h010) begin
      if (id < NS && m_held[id]) begin
        m_held[id] = 0;
        void'(stk.pop_back());
        if (!m_split) m_act[id] = 0;
      end
    end else if (a == 12'h014) begin
      if (id < NS && m_split) m_act[id] = 0;
    end else if (a[11:8] == 4'h1) begin
      for (int b = 0; b < 32; b++)
        if (a[7:2] * 32 + b < NS) m_en[a[7:2]*32+b] = d[b];
    end else if (a >= 12'h400 && (a - 12'h400) / 4 < NS) m_prio[(a - 12'h400) / 4] = d[7:0];
  endfunction

  // R2 R10 R11 R13: cpu_irq against the model on every clock
  always @(negedge clk) begin
    if (live) begin
      checks++;
      if (cpu_irq !== (m_best() != 1023)) begin
        fails++;
        $display("FAIL R2 cpu_irq actual=%0b expected=%0b at %0t", cpu_irq, m_best() != 1023, $time);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
    m_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic [31:0] e;
    int id;
    reg_rd = 1; reg_addr = a;
    #1;
    e = m_read(a);
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, e);
    end
    @(posedge clk); #1;
    reg_rd = 0;
    if (a == 12'h00C) begin
      id = m_best();
      if (id != 1023) begin
        m_act[id] = 1; m_held[id] = 1;
        stk.push_back(m_prio[id]);
      end
    end
  endtask

  task automatic set_lines(input logic [NS-1:0] v);
    lines = v;
    @(posedge clk); #1;
  endtask

  function automatic logic [11:0] pa(input int id);
    return 12'(12'h400 + 4 * id);
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_act[i] = 0; m_held[i] = 0; m_prio[i] = 0; end
    m_split = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    live = 1;
    // R1 R10: lines high, nothing enabled
    set_lines('1);
    rd(12'h000, "R1 ctrl");
    rd(12'h100, "R1 enable0");
    rd(12'h104, "R1 enable1");
    rd(12'h300, "R1 active0");
    rd(12'h00C, "R4 spurious after reset");
    rd(12'h304, "R4 active1 unchanged");
    set_lines('0);

    wr(pa(3), 32'h40); wr(pa(5), 32'h40); wr(pa(35), 32'h10); wr(pa(7), 32'h50);
    wr(pa(10), 32'h30); wr(pa(11), 32'h20); wr(pa(12), 32'h08); wr(pa(20), 32'h00);
    rd(pa(35), "R12 prio readback");
    wr(12'h100, 32'hFFFF_FFFF); wr(12'h104, 32'h0000_00FF);
    rd(12'h104, "R12 enable1 padding");

    // R3 tie between 3 and 5; R11 5 blocked at equal priority
    set_lines(NS'(1) << 3 | NS'(1) << 5);
    rd(12'h00C, "R3 tie to lower id");
    rd(12'h300, "R12 active0");
    // R11 more urgent source preempts
    set_lines(lines | NS'(1) << 35);
    rd(12'h00C, "R11 preempt ack");
    rd(12'h304, "R12 active1");
    // R5 R9 combined mode, line still high
    wr(12'h010, 32'd35);
    rd(12'h304, "R5 active cleared");
    rd(12'h00C, "R9 refire ack");
    wr(12'h010, 32'd35);
    set_lines(lines & ~(NS'(1) << 35));
    // R8 EOI for never acknowledged id
    wr(12'h010, 32'd7);
    wr(12'h010, 32'd1000);
    // R7 deactivate ignored in combined mode
    wr(12'h014, 32'd3);
    rd(12'h300, "R7 active kept");
    wr(12'h010, 32'd3);
    rd(12'h00C, "R9 source 3 again");
    set_lines(lines & ~(NS'(1) << 3));
    wr(12'h010, 32'd3);

    // R6 split mode
    wr(12'h000, 32'd1);
    rd(12'h000, "R6 ctrl");
    rd(12'h00C, "R6 ack 5");
    wr(12'h010, 32'd5);
    rd(12'h300, "R6 still active after drop");
    wr(12'h010, 32'd5);
    rd(12'h300, "R8 second drop ignored");
    wr(12'h014, 32'd5);
    rd(12'h00C, "R6 R9 refire after deactivate");
    wr(12'h014, 32'd5);
    rd(12'h300, "R6 deactivated while held");
    wr(12'h010, 32'd5);
    rd(12'h300, "R6 after drop");

    // R10 masking
    wr(12'h100, 32'hFFFF_FFDF);
    rd(12'h00C, "R10 masked gives spurious");
    set_lines('0);

    // R13 nest to full depth
    set_lines(NS'(1) << 10);
    rd(12'h00C, "R13 level1");
    set_lines(lines | NS'(1) << 11);
    rd(12'h00C, "R13 level2");
    set_lines(lines | NS'(1) << 12);
    rd(12'h00C, "R13 level3");
    set_lines(lines | NS'(1) << 20);
    rd(12'h00C, "R13 full gives spurious");
    wr(12'h010, 32'd12);
    rd(12'h00C, "R13 after drop");
    rd(12'h300, "R12 final active0");

    live = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule